// File: doc/BRIEF.md
# Bit-Plane Block Transfer Engine

This block moves rectangular areas of a one-bit-per-pixel frame buffer that is stored as 16-bit words. The frame buffer is a synchronous RAM inside the block. A CPU port reaches that RAM and also a small set of configuration registers. The registers hold the access mode, a shift amount, a per-bit write mask, a 4-bit logic-function code, a source-data selector and the upper destination address bits.

In normal mode the CPU reads and writes words of the frame buffer directly. In transfer mode, a CPU write to a frame-buffer address starts a read-modify-write sequence. The block reads the source word at the written address. It joins that word with the previously read source word, which sits in a holding register, and shifts the pair. It then combines the shifted word with the destination word through the selected logic function and writes the result back under the mask. The destination address is taken from the write data, and the upper destination bits come from a register. A CPU read in transfer mode only loads the holding register, so software can prime it before a span when the pixel alignment requires one extra source word.

Top module: `bitplane_blit`

## Requirements
- R1: After reset, cpu_ready is 1, cpu_rvalid is 0 and disp_en is 0. The registers start with mode normal (111), shift 0, mask 0xFFFF, logic code 3, the logic unit disabled, plane data selected and the high destination bits 0.
- R2: A frame-buffer access uses cpu_sel=0. In normal mode a write stores cpu_wdata at cpu_addr at once. A read is answered with cpu_rvalid=1 and the stored word on cpu_rdata in the cycle after acceptance. No shift, logic function or mask is applied in either case.
- R3: Transfer mode is entered when register 0 holds 100 in bits 7:5. A frame-buffer write in that mode reads the source at cpu_addr and writes the destination word at {high bits, cpu_wdata[7:0]}. cpu_ready is 0 for the two cycles after acceptance and is 1 again in the third.
- R4: Register 5 bits 3:0 hold the logic code, and register 1 bit 4 enables it. With S as the source and D as the destination, the codes give: 0 zero, 1 S&D, 2 S&~D, 3 S, 4 ~S&D, 5 D, 6 S^D, 7 S|D, 8 ~(S|D), 9 ~(S^D), A ~D, B S|~D, C ~S, D ~S|D, E ~(S&D), F ones. With the unit disabled the result is S.
- R5: Register 0 bits 3:0 set the shift s, and bit 4 is ignored. Bit i of the shifted source is cur[i+s] when i+s<16 and hold[i+s-16] otherwise. Each transfer then loads its source word into the holding register.
- R6: A frame-buffer read in transfer mode returns the source word with cpu_rvalid one cycle later. It loads that word into the holding register and writes nothing.
- R7: Register 4 is the write mask. A result bit replaces the destination bit only where the mask bit is 1, and a zero mask leaves the destination unchanged.
- R8: Register 2 bits 7:6 select the source data: 00 gives all ones, 01 copies bit 0 of the read word to all 16 bits, and 10 or 11 pass the read word.
- R9: Register 3 bits 1:0 hold the high destination bits. Writing register 3 with bit 7 set also clears the holding register, sets the mask to 0xFFFF and returns register 0 to normal mode with shift 0.
- R10: disp_en follows bit 0 of register 1.
- R11: While cpu_ready is 0, a request of any kind is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, taken when cpu_ready is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_sel | input | 1 | 0 = frame buffer, 1 = register (index in cpu_addr[2:0]) |
| cpu_addr | input | 10 | Word address or register index |
| cpu_wdata | input | 16 | Write data; destination low address bits in transfer mode |
| cpu_ready | output | 1 | Block idle and able to take an access |
| cpu_rvalid | output | 1 | Read data valid |
| cpu_rdata | output | 16 | Read data |
| disp_en | output | 1 | Display enable from register 1 bit 0 |

## Verification
A normal write takes effect at its accepting edge. Read data and cpu_rvalid appear in the cycle after acceptance, so the bench samples them at the falling edge that follows the accepting rising edge. A transfer write keeps cpu_ready low at the first two falling edges after acceptance and raises it at the third, and the bench checks all three edges before it reads the destination back in normal mode. Expected words come from a reference logic function and a bitwise shift model in the bench, which run in the same order as the transfers so that the holding-register contents are known.

// File: rtl/blit_pkg.sv
package blit_pkg;
    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    localparam logic [2:0] MODE_BLIT   = 3'b100;
    localparam logic [2:0] MODE_NORMAL = 3'b111;

    localparam logic [2:0] REG_CTRL0 = 3'd0;
    localparam logic [2:0] REG_CTRL1 = 3'd1;
    localparam logic [2:0] REG_SRCSEL = 3'd2;
    localparam logic [2:0] REG_HIADDR = 3'd3;
    localparam logic [2:0] REG_WMASK = 3'd4;
    localparam logic [2:0] REG_LOGIC = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC,
        ST_DST,
        ST_PRE,
        ST_RD
    } seq_state_e;

    function automatic word_t pick_source(input logic [1:0] sel, input word_t raw);
        case (sel)
            2'b00:   return '1;
            2'b01:   return {WORD_W{raw[0]}};
            default: return raw;
        endcase
    endfunction
endpackage

// File: rtl/blit_regs.sv
module blit_regs
    import blit_pkg::*;
#(
    parameter int HI_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_idx,
    input  word_t           wr_data,
    output logic [2:0]      mode,
    output logic [3:0]      shift,
    output logic            rop_en,
    output logic            disp_en,
    output logic [1:0]      src_sel,
    output logic [HI_W-1:0] hi_addr,
    output word_t           wmask,
    output logic [3:0]      rop_code
);
    typedef struct packed {
        logic [7:0]      ctrl0;
        logic [7:0]      ctrl1;
        logic [1:0]      src;
        logic [HI_W-1:0] hi;
        word_t           mask;
        logic [3:0]      code;
    } regs_t;

    regs_t q, d;

    localparam logic [7:0] CTRL0_RST = {MODE_NORMAL, 5'd0};

    always_comb begin
        d = q;
        if (wr_en) begin
            case (wr_idx)
                REG_CTRL0:  d.ctrl0 = wr_data[7:0];
                REG_CTRL1:  d.ctrl1 = wr_data[7:0];
                REG_SRCSEL: d.src   = wr_data[7:6];
                REG_HIADDR: begin
                    d.hi = wr_data[HI_W-1:0];
                    if (wr_data[7]) begin
                        d.ctrl0 = CTRL0_RST;
                        d.mask  = '1;
                    end
                end
                REG_WMASK:  d.mask = wr_data;
                REG_LOGIC:  d.code = wr_data[3:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ctrl0 <= CTRL0_RST;
            q.ctrl1 <= 8'h00;
            q.src   <= 2'b11;
            q.hi    <= '0;
            q.mask  <= '1;
            q.code  <= 4'h3;
        end else begin
            q <= d;
        end
    end

    assign mode     = q.ctrl0[7:5];
    assign shift    = q.ctrl0[3:0];
    assign rop_en   = q.ctrl1[4];
    assign disp_en  = q.ctrl1[0];
    assign src_sel  = q.src;
    assign hi_addr  = q.hi;
    assign wmask    = q.mask;
    assign rop_code = q.code;

    // R9
    clear_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == REG_HIADDR && wr_data[7])
        |=> (mode == MODE_NORMAL && shift == 4'd0 && wmask == '1));

    // R10
    disp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == REG_CTRL1) |=> (disp_en == $past(wr_data[0])));
endmodule

// File: rtl/blit_rop.sv
module blit_rop
    import blit_pkg::*;
(
    input  word_t      hold,
    input  word_t      cur,
    input  word_t      dst,
    input  logic [3:0] shift,
    input  logic       rop_en,
    input  logic [3:0] rop_code,
    input  word_t      wmask,
    output word_t      result
);
    localparam int PAIR_W = 2 * WORD_W;

    logic [PAIR_W-1:0] pair;
    word_t             shifted;
    word_t             func;

    always_comb begin
        pair    = {hold, cur} >> shift;
        shifted = pair[WORD_W-1:0];
    end

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        always_comb begin
            if (rop_en) func[i] = rop_code[{~shifted[i], ~dst[i]}];
            else        func[i] = shifted[i];
        end
    end

    assign result = (wmask & func) | (~wmask & dst);
endmodule

// File: rtl/blit_ram.sv
module blit_ram
    import blit_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  word_t             wdata,
    output word_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end
endmodule

// File: rtl/bitplane_blit.sv
module bitplane_blit
    import blit_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LO_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_sel,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [15:0]       cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic [15:0]       cpu_rdata,
    output logic              disp_en
);
    localparam int HI_W = ADDR_W - LO_W;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] dst;
        word_t             src;
        word_t             hold;
    } seq_t;

    seq_t q, d;

    logic [2:0]        mode;
    logic [3:0]        shift;
    logic              rop_en;
    logic [1:0]        src_sel;
    logic [HI_W-1:0]   hi_addr;
    word_t             wmask;
    logic [3:0]        rop_code;
    logic              acc;
    logic              reg_we;
    logic              hold_clear;
    logic              blit_mode;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    word_t             ram_wdata;
    word_t             ram_q;
    word_t             rop_out;

    assign cpu_ready  = (q.st == ST_IDLE);
    assign acc        = cpu_req && cpu_ready;
    assign reg_we     = acc && cpu_sel && cpu_we;
    assign hold_clear = reg_we && (cpu_addr[2:0] == REG_HIADDR) && cpu_wdata[7];
    assign blit_mode  = (mode == MODE_BLIT);

    blit_regs #(.HI_W(HI_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .wr_idx   (cpu_addr[2:0]),
        .wr_data  (cpu_wdata),
        .mode     (mode),
        .shift    (shift),
        .rop_en   (rop_en),
        .disp_en  (disp_en),
        .src_sel  (src_sel),
        .hi_addr  (hi_addr),
        .wmask    (wmask),
        .rop_code (rop_code)
    );

    blit_ram #(.ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_q)
    );

    blit_rop u_rop (
        .hold     (q.hold),
        .cur      (q.src),
        .dst      (ram_q),
        .shift    (shift),
        .rop_en   (rop_en),
        .rop_code (rop_code),
        .wmask    (wmask),
        .result   (rop_out)
    );

    always_comb begin
        d         = q;
        ram_addr  = cpu_addr;
        ram_we    = 1'b0;
        ram_wdata = cpu_wdata;
        case (q.st)
            ST_IDLE: begin
                if (acc) begin
                    if (cpu_sel) begin
                        if (hold_clear) d.hold = '0;
                    end else if (cpu_we) begin
                        if (blit_mode) begin
                            d.dst = {hi_addr, cpu_wdata[LO_W-1:0]};
                            d.st  = ST_SRC;
                        end else begin
                            ram_we = 1'b1;
                        end
                    end else begin
                        d.st = blit_mode ? ST_PRE : ST_RD;
                    end
                end
            end
            ST_SRC: begin
                ram_addr = q.dst;
                d.src    = pick_source(src_sel, ram_q);
                d.st     = ST_DST;
            end
            ST_DST: begin
                ram_addr  = q.dst;
                ram_we    = 1'b1;
                ram_wdata = rop_out;
                d.hold    = q.src;
                d.st      = ST_IDLE;
            end
            ST_PRE: begin
                d.hold = pick_source(src_sel, ram_q);
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.dst  <= '0;
            q.src  <= '0;
            q.hold <= '0;
        end else begin
            q <= d;
        end
    end

    assign cpu_rvalid = (q.st == ST_PRE) || (q.st == ST_RD);
    assign cpu_rdata  = ram_q;

    // R3
    blit_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !cpu_sel && cpu_we && blit_mode)
        |=> !cpu_ready ##1 !cpu_ready ##1 cpu_ready);

    // R2
    rvalid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> $past(cpu_req && cpu_ready && !cpu_we && !cpu_sel));

    // R6
    preread_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_PRE) |-> !ram_we);

    // R7
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DST && wmask == '0) |-> (ram_wdata == ram_q));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_ready) |=> ($stable(wmask) && $stable(rop_code) && $stable(mode)));
endmodule

// File: tb/bitplane_blit_test.sv
module bitplane_blit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic        cpu_sel = 1'b0;
    logic [9:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_ready;
    logic        cpu_rvalid;
    logic [15:0] cpu_rdata;
    logic        disp_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bitplane_blit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_req    (cpu_req),
        .cpu_we     (cpu_we),
        .cpu_sel    (cpu_sel),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_ready  (cpu_ready),
        .cpu_rvalid (cpu_rvalid),
        .cpu_rdata  (cpu_rdata),
        .disp_en    (disp_en)
    );

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] rop_ref(input logic [3:0] c, input logic [15:0] s, input logic [15:0] t);
        case (c)
            4'h0: return 16'h0000;
            4'h1: return s & t;
            4'h2: return s & ~t;
            4'h3: return s;
            4'h4: return ~s & t;
            4'h5: return t;
            4'h6: return s ^ t;
            4'h7: return s | t;
            4'h8: return ~(s | t);
            4'h9: return ~(s ^ t);
            4'hA: return ~t;
            4'hB: return s | ~t;
            4'hC: return ~s;
            4'hD: return ~s | t;
            4'hE: return ~(s & t);
            default: return 16'hFFFF;
        endcase
    endfunction

    function automatic logic [15:0] shf_ref(input logic [15:0] hold, input logic [15:0] cur, input int s);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = (i + s < 16) ? cur[i + s] : hold[i + s - 16];
        return r;
    endfunction

    task automatic wr(input logic sel, input logic [9:0] a, input logic [15:0] v);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_sel = sel; cpu_addr = a; cpu_wdata = v;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [15:0] v, input string tag);
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_sel = 1'b0; cpu_addr = a;
        @(negedge clk);
        check(cpu_rvalid === 1'b1, tag, {15'd0, cpu_rvalid}, 16'd1);
        v = cpu_rdata;
        cpu_req = 1'b0;
    endtask

    task automatic set_reg(input logic [2:0] idx, input logic [15:0] v);
        wr(1'b1, {7'd0, idx}, v);
    endtask

    task automatic mem_check(input logic [9:0] a, input logic [15:0] exp, input string tag);
        logic [15:0] v;
        set_reg(3'd0, 16'h00E0);
        rd(a, v, tag);
        check(v === exp, tag, v, exp);
    endtask

    // transfer write with the ready timing check of R3
    task automatic blit(input logic [9:0] src_a, input logic [15:0] dst_lo, input logic [7:0] c0);
        set_reg(3'd0, {8'd0, c0});
        wr(1'b0, src_a, dst_lo);
        check(cpu_ready === 1'b0, "R3 busy cycle 1", {15'd0, cpu_ready}, 16'd0);
        @(negedge clk);
        check(cpu_ready === 1'b0, "R3 busy cycle 2", {15'd0, cpu_ready}, 16'd0);
        @(negedge clk);
        check(cpu_ready === 1'b1, "R3 ready again", {15'd0, cpu_ready}, 16'd1);
    endtask

    task automatic test_reset;
        check(cpu_ready === 1'b1, "R1 ready", {15'd0, cpu_ready}, 16'd1);
        check(cpu_rvalid === 1'b0, "R1 rvalid", {15'd0, cpu_rvalid}, 16'd0);
        check(disp_en === 1'b0, "R1 R10 display off", {15'd0, disp_en}, 16'd0);
    endtask

    task automatic test_normal;
        logic [15:0] v;
        wr(1'b0, 10'h003, 16'hDEAD);
        wr(1'b0, 10'h3FF, 16'h0001);
        wr(1'b0, 10'h200, 16'h8000);
        rd(10'h003, v, "R2 rvalid"); check(v === 16'hDEAD, "R2 read a", v, 16'hDEAD);
        rd(10'h3FF, v, "R2 rvalid"); check(v === 16'h0001, "R2 read b", v, 16'h0001);
        rd(10'h200, v, "R2 rvalid"); check(v === 16'h8000, "R2 read c", v, 16'h8000);
    endtask

    task automatic test_basic_blit;
        set_reg(3'd3, 16'h0001);
        wr(1'b0, 10'h010, 16'hA5C3);
        wr(1'b0, 10'h120, 16'h0000);
        blit(10'h010, 16'h0020, 8'h80);
        mem_check(10'h120, 16'hA5C3, "R3 dest copy");
        mem_check(10'h010, 16'hA5C3, "R3 source kept");
    endtask

    task automatic test_rop;
        set_reg(3'd1, 16'h0011);
        check(disp_en === 1'b1, "R10 display on", {15'd0, disp_en}, 16'd1);
        wr(1'b0, 10'h030, 16'h3C5A);
        for (int c = 0; c < 16; c++) begin
            set_reg(3'd0, 16'h00E0);
            wr(1'b0, 10'h130, 16'h0FF0);
            set_reg(3'd5, c[15:0]);
            blit(10'h030, 16'h0030, 8'h80);
            mem_check(10'h130, rop_ref(c[3:0], 16'h3C5A, 16'h0FF0), "R4 logic code");
        end
        set_reg(3'd5, 16'h0006);
        set_reg(3'd1, 16'h0001);
        check(disp_en === 1'b1, "R10 display stays", {15'd0, disp_en}, 16'd1);
        wr(1'b0, 10'h131, 16'hFFFF);
        blit(10'h030, 16'h0031, 8'h80);
        mem_check(10'h131, 16'h3C5A, "R4 disabled passes source");
    endtask

    task automatic test_shift;
        set_reg(3'd3, 16'h0081);
        wr(1'b0, 10'h040, 16'h1234);
        wr(1'b0, 10'h041, 16'hABCD);
        wr(1'b0, 10'h042, 16'h0F0F);
        blit(10'h040, 16'h0040, 8'h85);
        mem_check(10'h140, shf_ref(16'h0000, 16'h1234, 5), "R5 first word");
        blit(10'h041, 16'h0041, 8'h85);
        mem_check(10'h141, shf_ref(16'h1234, 16'hABCD, 5), "R5 second word");
        blit(10'h042, 16'h0042, 8'h95);
        mem_check(10'h142, shf_ref(16'hABCD, 16'h0F0F, 5), "R5 bit 4 ignored");
    endtask

    task automatic test_preread;
        logic [15:0] v;
        set_reg(3'd3, 16'h0081);
        wr(1'b0, 10'h050, 16'hF00F);
        wr(1'b0, 10'h051, 16'h1111);
        wr(1'b0, 10'h150, 16'h7777);
        set_reg(3'd0, 16'h0084);
        rd(10'h050, v, "R6 rvalid");
        check(v === 16'hF00F, "R6 pre-read data", v, 16'hF00F);
        mem_check(10'h050, 16'hF00F, "R6 source unchanged");
        mem_check(10'h150, 16'h7777, "R6 no write");
        blit(10'h051, 16'h0050, 8'h84);
        mem_check(10'h150, shf_ref(16'hF00F, 16'h1111, 4), "R6 hold loaded");
    endtask

    task automatic test_mask;
        wr(1'b0, 10'h060, 16'h5555);
        wr(1'b0, 10'h160, 16'hAAAA);
        set_reg(3'd4, 16'h00FF);
        blit(10'h060, 16'h0060, 8'h80);
        mem_check(10'h160, 16'hAA55, "R7 partial mask");
        wr(1'b0, 10'h161, 16'h1234);
        set_reg(3'd4, 16'h0000);
        blit(10'h060, 16'h0061, 8'h80);
        mem_check(10'h161, 16'h1234, "R7 zero mask");
        set_reg(3'd4, 16'hFFFF);
    endtask

    task automatic test_srcsel;
        wr(1'b0, 10'h070, 16'h1230);
        wr(1'b0, 10'h071, 16'h0001);
        set_reg(3'd2, 16'h0000);
        blit(10'h070, 16'h0070, 8'h80);
        mem_check(10'h170, 16'hFFFF, "R8 all ones");
        set_reg(3'd2, 16'h0040);
        blit(10'h071, 16'h0071, 8'h80);
        mem_check(10'h171, 16'hFFFF, "R8 replicate one");
        blit(10'h070, 16'h0072, 8'h80);
        mem_check(10'h172, 16'h0000, "R8 replicate zero");
        set_reg(3'd2, 16'h00C0);
        blit(10'h070, 16'h0073, 8'h80);
        mem_check(10'h173, 16'h1230, "R8 plane data");
    endtask

    task automatic test_clear;
        logic [15:0] v;
        wr(1'b0, 10'h080, 16'hBEEF);
        wr(1'b0, 10'h081, 16'h4242);
        blit(10'h081, 16'h0080, 8'h80);
        set_reg(3'd4, 16'h0F0F);
        set_reg(3'd0, 16'h0088);
        set_reg(3'd3, 16'h0081);
        rd(10'h080, v, "R9 normal read after clear");
        check(v === 16'hBEEF, "R9 mode back to normal", v, 16'hBEEF);
        wr(1'b0, 10'h181, 16'h0000);
        blit(10'h080, 16'h0081, 8'h88);
        mem_check(10'h181, 16'h00BE, "R9 hold and mask cleared");
    endtask

    task automatic test_busy_ignore;
        wr(1'b0, 10'h090, 16'hC3C3);
        wr(1'b0, 10'h190, 16'h0000);
        wr(1'b0, 10'h191, 16'h0000);
        set_reg(3'd0, 16'h0080);
        wr(1'b0, 10'h090, 16'h0090);
        check(cpu_ready === 1'b0, "R11 busy", {15'd0, cpu_ready}, 16'd0);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_sel = 1'b1; cpu_addr = 10'h004; cpu_wdata = 16'h0000;
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0; cpu_sel = 1'b0;
        blit(10'h090, 16'h0091, 8'h80);
        mem_check(10'h191, 16'hC3C3, "R11 mask write ignored");
        mem_check(10'h190, 16'hC3C3, "R11 first transfer done");
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_normal();
        test_basic_blit();
        test_rop();
        test_shift();
        test_preread();
        test_mask();
        test_srcsel();
        test_clear();
        test_busy_ignore();
        finish_run();
    end
endmodule